// File: doc/BRIEF.md
# Least-Recently-Served Output Arbiter

This block settles contention for a single output port of a network-on-chip router. Up to five input ports can ask for the output in the same cycle. The arbiter picks one of them and returns a one-hot grant, a binary select that drives the output multiplexer, and a flag saying that a grant exists. The choice is made combinationally from the current requests and a small register of pairwise precedence bits.

Every pair of inputs has one precedence bit that records which of the two ranks ahead. Only the pairs with the lower index first are stored, so five inputs need ten bits. The reverse direction of each pair is read as the complement. When an input wins, the state register makes it rank behind every other input on the next clock edge. The input that was served longest ago therefore moves to the front. After reset, input 0 ranks first and input 4 ranks last.

The request, grant and select pins are plain control signals. The arbiter applies no back-pressure of its own. A grant is taken as consumed in the cycle it is shown, and the priority update follows on that clock edge.

Top module: `tri_lrs_arbiter`

## Requirements
- R1: After a synchronous active-high reset, the ranking runs from input 0 (first) to input 4 (last). With all five inputs requesting, input 0 is granted first.
- R2: In any cycle, the grant has at most one bit set, and that bit is a requesting input. The granted input is the requester that ranks ahead of every other current requester.
- R3: On the clock edge after a grant to input w, input w drops to last place in the ranking.
- R4: On a grant, the relative order of the inputs that were not granted stays the same.
- R5: With no request, the grant is all zeros, the valid flag is low, and the ranking is unchanged on the next edge.
- R6: While the valid flag is high, the select output holds the binary index of the granted input, where grant bit k means select value k. The valid flag is high exactly when some input requests.
- R7: The grant, select and valid outputs follow the requests in the same cycle, with no register stage in between.
- R8: A reset asserted in the middle of operation restores the ranking of R1.
- R9: A lone requester is always granted, whatever its rank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 5 | Request per input port, bit k is input k |
| gnt_o | output | 5 | One-hot grant, bit k is input k |
| sel_o | output | 3 | Binary index of the granted input, for the output multiplexer |
| vld_o | output | 1 | High when a grant is present |

## Verification
The assertions place no protocol on the request lines. Any pattern may appear in any cycle, and a request may drop without having been granted. The only input assumption is that reset is a clean synchronous level, sampled at the clock edge. The stimulus drives requests at the falling edge, so the pattern is stable around each rising edge. Patterns are drawn at random with a bias toward dense contention and occasional idle cycles. Directed sequences cover full contention, a lone low-ranked requester and reset asserted mid-stream.

// File: rtl/tri_arb_pkg.sv
package tri_arb_pkg;

  // Number of stored precedence bits for n requesters.
  function automatic int tri_bits(input int n);
    return (n * (n - 1)) / 2;
  endfunction

  // Linear position of the pair (hi, lo), hi < lo, in the triangle store.
  function automatic int pair_idx(input int hi, input int lo, input int n);
    return hi * n - (hi * (hi + 1)) / 2 + (lo - hi - 1);
  endfunction

endpackage

// File: rtl/prio_tri_store.sv
module prio_tri_store
  import tri_arb_pkg::*;
#(
  parameter int N_REQ = 5,
  localparam int TRI_W = tri_bits(N_REQ)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [N_REQ-1:0] win_oh,
  output logic [TRI_W-1:0] tri_q
);

  logic [TRI_W-1:0] tri_d;

  // Bit set: the lower index of the pair ranks ahead of the higher one.
  for (genvar gi = 0; gi < N_REQ; gi++) begin : g_row
    for (genvar gj = gi + 1; gj < N_REQ; gj++) begin : g_col
      localparam int K = pair_idx(gi, gj, N_REQ);
      always_comb begin
        if (win_oh[gi])      tri_d[K] = 1'b0;
        else if (win_oh[gj]) tri_d[K] = 1'b1;
        else                 tri_d[K] = tri_q[K];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         tri_q <= '1;
    else if (upd_en) tri_q <= tri_d;
  end

endmodule

// File: rtl/prio_grant_pick.sv
module prio_grant_pick
  import tri_arb_pkg::*;
#(
  parameter int N_REQ = 5,
  localparam int TRI_W = tri_bits(N_REQ)
) (
  input  logic [N_REQ-1:0] req,
  input  logic [TRI_W-1:0] tri_q,
  output logic [N_REQ-1:0] gnt
);

  // ok_row[i][j]: input j does not block input i.
  logic [N_REQ-1:0] ok_row [N_REQ];

  for (genvar gi = 0; gi < N_REQ; gi++) begin : g_row
    for (genvar gj = 0; gj < N_REQ; gj++) begin : g_col
      if (gi == gj) begin : g_self
        assign ok_row[gi][gj] = 1'b1;
      end else if (gi < gj) begin : g_upper
        assign ok_row[gi][gj] = ~req[gj] | tri_q[pair_idx(gi, gj, N_REQ)];
      end else begin : g_lower
        assign ok_row[gi][gj] = ~req[gj] | ~tri_q[pair_idx(gj, gi, N_REQ)];
      end
    end
    assign gnt[gi] = req[gi] & (&ok_row[gi]);
  end

endmodule

// File: rtl/onehot_to_index.sv
module onehot_to_index #(
  parameter int N_REQ = 5,
  localparam int SEL_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0] oh,
  output logic [SEL_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int k = 0; k < N_REQ; k++) begin
      if (oh[k]) idx = idx | SEL_W'(k);
    end
  end

endmodule

// File: rtl/tri_lrs_arbiter.sv
module tri_lrs_arbiter
  import tri_arb_pkg::*;
#(
  parameter int N_REQ = 5,
  localparam int SEL_W = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int TRI_W = tri_bits(N_REQ)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] gnt_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             vld_o
);

  logic [TRI_W-1:0] tri_q;
  logic [N_REQ-1:0] gnt;

  prio_grant_pick #(.N_REQ(N_REQ)) u_pick (
    .req   (req_i),
    .tri_q (tri_q),
    .gnt   (gnt)
  );

  onehot_to_index #(.N_REQ(N_REQ)) u_enc (
    .oh  (gnt),
    .idx (sel_o)
  );

  prio_tri_store #(.N_REQ(N_REQ)) u_store (
    .clk    (clk),
    .rst    (rst),
    .upd_en (vld_o),
    .win_oh (gnt),
    .tri_q  (tri_q)
  );

  assign gnt_o = gnt;
  assign vld_o = |gnt;

endmodule

// File: rtl/tri_lrs_arbiter_chk.sv
module tri_lrs_arbiter_chk #(
  parameter int N_REQ = 5,
  parameter int SEL_W = 3,
  parameter int TRI_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [N_REQ-1:0] req_i,
  input logic [N_REQ-1:0] gnt_o,
  input logic [SEL_W-1:0] sel_o,
  input logic             vld_o,
  input logic [TRI_W-1:0] tri_q
);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o)); // R2

  AST_GNT_WITHIN_REQ: assert property (@(posedge clk) disable iff (rst)
    (gnt_o & ~req_i) == '0); // R2

  AST_VLD_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    vld_o == (req_i != '0)); // R6

  AST_SEL_POINTS_GNT: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> ((gnt_o >> sel_o) & N_REQ'(1)) != '0); // R6

  AST_WINNER_YIELDS: assert property (@(posedge clk) disable iff (rst)
    vld_o |=> (((req_i & ~$past(gnt_o)) == '0) || ((gnt_o & $past(gnt_o)) == '0))); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !vld_o |=> $stable(tri_q)); // R5

  AST_RESET_ORDER: assert property (@(posedge clk)
    rst |=> (tri_q == '1)); // R8

endmodule

bind tri_lrs_arbiter tri_lrs_arbiter_chk #(
  .N_REQ(N_REQ), .SEL_W(SEL_W), .TRI_W(TRI_W)
) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .gnt_o(gnt_o),
  .sel_o(sel_o), .vld_o(vld_o), .tri_q(tri_q)
);

// File: tb/tri_lrs_arbiter_test.sv
module tri_lrs_arbiter_test;

  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req_i = '0;
  logic [N-1:0] gnt_o;
  logic [2:0]   sel_o;
  logic         vld_o;

  int n_run  = 0;
  int n_fail = 0;
  int order [N];

  always #5 clk = ~clk;

  tri_lrs_arbiter uut (
    .clk(clk), .rst(rst), .req_i(req_i),
    .gnt_o(gnt_o), .sel_o(sel_o), .vld_o(vld_o)
  );

  task automatic model_reset();
    for (int k = 0; k < N; k++) order[k] = k;
  endtask

  function automatic int model_winner(input logic [N-1:0] r);
    for (int k = 0; k < N; k++) if (r[order[k]]) return order[k];
    return -1;
  endfunction

  task automatic model_serve(input int w);
    int pos = 0;
    for (int k = 0; k < N; k++) if (order[k] == w) pos = k;
    for (int k = pos; k < N - 1; k++) order[k] = order[k + 1];
    order[N - 1] = w;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive a pattern at the falling edge, check the outputs in the same cycle (R7).
  task automatic step(input logic [N-1:0] r, input string tag);
    int w;
    logic [N-1:0] eg;
    @(negedge clk);
    req_i = r;
    #1;
    w  = model_winner(r);
    eg = (w < 0) ? '0 : (N'(1) << w);
    check(gnt_o == eg, {tag, " R2 R7 grant"}, int'(gnt_o), int'(eg));
    check(vld_o == (w >= 0), {tag, " R6 valid"}, int'(vld_o), int'(w >= 0));
    if (w >= 0) begin
      check(int'(sel_o) == w, {tag, " R6 select"}, int'(sel_o), w);
      model_serve(w);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_i = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin : watchdog
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [N-1:0] r;
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    model_reset();
    do_reset();

    // Reset state with nothing requested (R1, R5).
    #1;
    check(gnt_o == '0 && vld_o == 1'b0, "R5 idle after reset", int'(gnt_o), 0);

    // Full contention walks the ring 0..4 twice (R1, R3, R4).
    for (int k = 0; k < 2 * N; k++) begin
      step('1, "R1 R3 full");
      check(int'(sel_o) == (k % N), "R3 full ring order", int'(sel_o), k % N);
    end

    // Idle cycles hold the ranking (R5).
    step(5'b00000, "R5 idle");
    step(5'b00000, "R5 idle");
    step(5'b11111, "R5 after idle");

    // Lone lowest-ranked requester (R9).
    step(5'b10000, "R9 lone");
    step(5'b10000, "R9 lone repeat");
    step(5'b10001, "R4 pair");
    step(5'b01010, "R4 pair b");

    // Mid-stream reset restores the initial order (R8).
    step(5'b00001, "R8 pre");
    do_reset();
    step(5'b11111, "R8 after reset");
    check(int'(sel_o) == 0, "R8 input 0 first", int'(sel_o), 0);

    // Constrained random: biased to dense contention, some idle.
    for (int k = 0; k < 3000; k++) begin
      r = N'($urandom);
      if (($urandom % 8) == 0) r = '0;
      else if (($urandom % 4) == 0) r = r | N'($urandom);
      step(r, "R2 R3 R4 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule